// File: doc/BRIEF.md
# Ternary Prefix Routing Cache

This block is a small bank of ternary pattern matchers. It sits in front of a slow full-table lookup and works as a fast routing cache. Each entry holds a care mask, a value and an output port number. A bit position whose mask bit is clear is a don't-care position. Software loads or clears entries one at a time through a configuration port.

Before it commits a write, the block checks two rules. An entry may hold only a few care bits. Two entries that can match the same address must name the same output port. A write that breaks either rule is dropped, and an error flag reports the reason.

A packet-timing strobe marks the cycle in which the upper destination-address bits of a header are valid. The block looks the key up on that strobe only. Inside each entry, the bits that must be one and the bits that must be zero are checked separately, and the two results are ANDed. One clock later the block reports one of two outcomes:
- a hit, together with the selected port, or
- a miss, which sends the packet to the auxiliary slow-path port.

Top module: `tpr_cache`

## Requirements
- R1: After reset, `res_vld`, `res_hit`, `res_miss`, `res_port`, `cfg_err_care` and `cfg_err_ovl` are 0, and every entry is invalid, so the first lookup misses.
- R2: A valid entry matches a key when every key bit at a set mask position equals the stored value bit there. Key bits at clear mask positions have no effect.
- R3: `res_vld` is high for exactly the one cycle after each cycle with `hdr_stb` high. `res_hit`, `res_miss` and `res_port` change only in that cycle and hold their values otherwise.
- R4: A lookup that matches no valid entry gives `res_miss`=1, `res_hit`=0 and `res_port`=0, which is the auxiliary path.
- R5: When several valid entries match, the result is a hit. The lowest-index matching entry supplies the port, and by R7 all matching entries name that same port.
- R6: A write with `cfg_valid`=1 and more than MAX_CARE (default 5) mask bits set raises `cfg_err_care` for one cycle after the write and leaves the entry unchanged. A write with exactly MAX_CARE bits is accepted.
- R7: A write with `cfg_valid`=1 is rejected when it overlaps a valid entry at another index that names a different port. The rejection raises `cfg_err_ovl` for one cycle after the write and leaves the entry unchanged. Two entries overlap when their values agree on every bit where both masks are set. Overlap with an entry that names the same port is accepted.
- R8: A write with `cfg_valid`=0 always commits and clears the entry, raises no error, and stops the entry from matching.
- R9: When a configuration write and `hdr_stb` fall in the same cycle, the lookup uses the table contents from before the write.
- R10: Rewriting an index is never checked for overlap against the entry it replaces.
- R11: Stored value bits at clear mask positions are ignored. They affect neither matching nor the overlap check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (3) | Entry index to write |
| cfg_valid | input | 1 | Valid bit of the written entry; 0 clears the entry |
| cfg_mask | input | KEY_W (24) | Care mask; 1 marks a compared bit |
| cfg_value | input | KEY_W (24) | Required bit values at the care positions |
| cfg_port | input | PORT_W (3) | Output port of the entry |
| cfg_err_care | output | 1 | Write rejected: too many care bits |
| cfg_err_ovl | output | 1 | Write rejected: overlaps an entry with another port |
| hdr_stb | input | 1 | Packet-timing strobe; the key is valid |
| hdr_key | input | KEY_W (24) | Upper destination-address bits |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup miss; packet goes to the auxiliary port |
| res_port | output | PORT_W (3) | Selected output port; 0 on a miss |

## Verification
The bench builds the block with its default parameters: a 24-bit key, eight entries, a 3-bit port and a care limit of five. With these values it can fill every entry with disjoint patterns and read every port number back, port 0 included. It can also probe the care limit on both sides, with five care bits accepted and six rejected. Overlap is exercised three ways: with disjoint masks, with an opposing bit value that makes two entries disjoint, and with a same-port overlap that must be accepted. A combined write and strobe in one cycle shows which table contents the lookup used.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  localparam int unsigned KEY_W_DEF    = 24;
  localparam int unsigned ENTRIES_DEF  = 8;
  localparam int unsigned PORT_W_DEF   = 3;
  localparam int unsigned MAX_CARE_DEF = 5;

  typedef struct packed {
    logic care;
    logic ovl;
  } cfg_err_t;
endpackage

// File: rtl/tpr_entry_match.sv
module tpr_entry_match #(
  parameter int unsigned KEY_W = tpr_pkg::KEY_W_DEF
) (
  input  logic             valid,
  input  logic [KEY_W-1:0] mask,
  input  logic [KEY_W-1:0] value,
  input  logic [KEY_W-1:0] key,
  output logic             hit
);
  logic [KEY_W-1:0] need_one, need_zero;
  logic             ones_ok, zeros_ok;

  always_comb begin
    need_one  = mask & value;
    need_zero = mask & ~value;
    ones_ok   = ((key & need_one) == need_one);
    zeros_ok  = ((~key & need_zero) == need_zero);
    hit       = valid & ones_ok & zeros_ok;
  end
endmodule

// File: rtl/tpr_cfg_check.sv
module tpr_cfg_check #(
  parameter int unsigned KEY_W    = tpr_pkg::KEY_W_DEF,
  parameter int unsigned ENTRIES  = tpr_pkg::ENTRIES_DEF,
  parameter int unsigned PORT_W   = tpr_pkg::PORT_W_DEF,
  parameter int unsigned MAX_CARE = tpr_pkg::MAX_CARE_DEF,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned CNT_W   = $clog2(KEY_W + 1)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              valid,
  input  logic [KEY_W-1:0]  mask,
  input  logic [KEY_W-1:0]  value,
  input  logic [PORT_W-1:0] port,
  input  logic              tbl_valid [ENTRIES],
  input  logic [KEY_W-1:0]  tbl_mask  [ENTRIES],
  input  logic [KEY_W-1:0]  tbl_value [ENTRIES],
  input  logic [PORT_W-1:0] tbl_port  [ENTRIES],
  output tpr_pkg::cfg_err_t err
);
  logic [CNT_W-1:0]   care_cnt;
  logic [ENTRIES-1:0] conflict;

  always_comb begin
    care_cnt = '0;
    for (int b = 0; b < KEY_W; b++) care_cnt = care_cnt + CNT_W'(mask[b]);
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ovl
    always_comb begin
      conflict[e] = tbl_valid[e] && (idx != IDX_W'(e)) &&
                    (((tbl_value[e] ^ value) & tbl_mask[e] & mask) == '0) &&
                    (tbl_port[e] != port);
    end
  end

  always_comb begin
    err.care = valid && (care_cnt > CNT_W'(MAX_CARE));
    err.ovl  = valid && (|conflict);
  end
endmodule

// File: rtl/tpr_select.sv
module tpr_select #(
  parameter int unsigned ENTRIES = tpr_pkg::ENTRIES_DEF,
  parameter int unsigned PORT_W  = tpr_pkg::PORT_W_DEF
) (
  input  logic [ENTRIES-1:0] hits,
  input  logic [PORT_W-1:0]  ports [ENTRIES],
  output logic               any,
  output logic [PORT_W-1:0]  port
);
  always_comb begin
    any  = |hits;
    port = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hits[e]) port = ports[e];
    end
  end
endmodule

// File: rtl/tpr_cache.sv
module tpr_cache #(
  parameter int unsigned KEY_W    = tpr_pkg::KEY_W_DEF,
  parameter int unsigned ENTRIES  = tpr_pkg::ENTRIES_DEF,
  parameter int unsigned PORT_W   = tpr_pkg::PORT_W_DEF,
  parameter int unsigned MAX_CARE = tpr_pkg::MAX_CARE_DEF,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [KEY_W-1:0]  cfg_mask,
  input  logic [KEY_W-1:0]  cfg_value,
  input  logic [PORT_W-1:0] cfg_port,
  output logic              cfg_err_care,
  output logic              cfg_err_ovl,
  input  logic              hdr_stb,
  input  logic [KEY_W-1:0]  hdr_key,
  output logic              res_vld,
  output logic              res_hit,
  output logic              res_miss,
  output logic [PORT_W-1:0] res_port
);
  logic              tbl_valid [ENTRIES];
  logic [KEY_W-1:0]  tbl_mask  [ENTRIES];
  logic [KEY_W-1:0]  tbl_value [ENTRIES];
  logic [PORT_W-1:0] tbl_port  [ENTRIES];

  logic [ENTRIES-1:0] hits;
  logic               any_hit;
  logic [PORT_W-1:0]  sel_port;
  logic [KEY_W-1:0]   norm_value;
  tpr_pkg::cfg_err_t  chk_err;
  logic               commit;

  assign norm_value = cfg_value & cfg_mask;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    tpr_entry_match #(.KEY_W(KEY_W)) match_i (
      .valid(tbl_valid[e]), .mask(tbl_mask[e]), .value(tbl_value[e]),
      .key(hdr_key), .hit(hits[e])
    );
  end

  tpr_select #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) sel_i (
    .hits(hits), .ports(tbl_port), .any(any_hit), .port(sel_port)
  );

  tpr_cfg_check #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .PORT_W(PORT_W),
                  .MAX_CARE(MAX_CARE)) chk_i (
    .idx(cfg_idx), .valid(cfg_valid), .mask(cfg_mask), .value(norm_value),
    .port(cfg_port), .tbl_valid(tbl_valid), .tbl_mask(tbl_mask),
    .tbl_value(tbl_value), .tbl_port(tbl_port), .err(chk_err)
  );

  assign commit = cfg_we && !chk_err.care && !chk_err.ovl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tbl_valid[e] <= 1'b0;
        tbl_mask[e]  <= '0;
        tbl_value[e] <= '0;
        tbl_port[e]  <= '0;
      end
    end else if (commit) begin
      tbl_valid[cfg_idx] <= cfg_valid;
      tbl_mask[cfg_idx]  <= cfg_mask;
      tbl_value[cfg_idx] <= norm_value;
      tbl_port[cfg_idx]  <= cfg_port;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld      <= 1'b0;
      res_hit      <= 1'b0;
      res_miss     <= 1'b0;
      res_port     <= '0;
      cfg_err_care <= 1'b0;
      cfg_err_ovl  <= 1'b0;
    end else begin
      res_vld      <= hdr_stb;
      cfg_err_care <= cfg_we && chk_err.care;
      cfg_err_ovl  <= cfg_we && chk_err.ovl;
      if (hdr_stb) begin
        res_hit  <= any_hit;
        res_miss <= !any_hit;
        res_port <= any_hit ? sel_port : '0;
      end
    end
  end
endmodule

// File: rtl/tpr_cache_chk.sv
module tpr_cache_chk #(
  parameter int unsigned KEY_W    = tpr_pkg::KEY_W_DEF,
  parameter int unsigned PORT_W   = tpr_pkg::PORT_W_DEF,
  parameter int unsigned MAX_CARE = tpr_pkg::MAX_CARE_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              cfg_valid,
  input logic [KEY_W-1:0]  cfg_mask,
  input logic              cfg_err_care,
  input logic              cfg_err_ovl,
  input logic              hdr_stb,
  input logic              res_vld,
  input logic              res_hit,
  input logic              res_miss,
  input logic [PORT_W-1:0] res_port
);
  p_vld_after_stb_r3: assert property (@(posedge clk) disable iff (rst)
    hdr_stb |=> res_vld);
  p_no_vld_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !hdr_stb |=> !res_vld);
  p_port_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(hdr_stb) |-> $stable(res_port));
  p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (res_hit ^ res_miss));
  p_miss_port_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_miss) |-> (res_port == '0));
  p_care_err_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_valid && ($countones(cfg_mask) > MAX_CARE)) |=> cfg_err_care);
  p_care_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ($countones(cfg_mask) <= MAX_CARE)) |=> !cfg_err_care);
  p_err_needs_we_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_err_care || cfg_err_ovl) |-> $past(cfg_we));
  p_clear_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_valid) |=> (!cfg_err_care && !cfg_err_ovl));
endmodule

bind tpr_cache tpr_cache_chk #(.KEY_W(KEY_W), .PORT_W(PORT_W), .MAX_CARE(MAX_CARE)) chk_bind_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_valid(cfg_valid),
  .cfg_mask(cfg_mask), .cfg_err_care(cfg_err_care), .cfg_err_ovl(cfg_err_ovl),
  .hdr_stb(hdr_stb), .res_vld(res_vld), .res_hit(res_hit),
  .res_miss(res_miss), .res_port(res_port)
);

// File: tb/tpr_cache_tb_top.sv
module tpr_cache_tb_top;
  localparam int KW = 24;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic          cfg_valid = 1'b0;
  logic [KW-1:0] cfg_mask = '0;
  logic [KW-1:0] cfg_value = '0;
  logic [PW-1:0] cfg_port = '0;
  logic          cfg_err_care, cfg_err_ovl;
  logic          hdr_stb = 1'b0;
  logic [KW-1:0] hdr_key = '0;
  logic          res_vld, res_hit, res_miss;
  logic [PW-1:0] res_port;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tpr_cache dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_mask(cfg_mask), .cfg_value(cfg_value),
    .cfg_port(cfg_port), .cfg_err_care(cfg_err_care), .cfg_err_ovl(cfg_err_ovl),
    .hdr_stb(hdr_stb), .hdr_key(hdr_key), .res_vld(res_vld),
    .res_hit(res_hit), .res_miss(res_miss), .res_port(res_port)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] idx, input logic v, input logic [KW-1:0] m,
                        input logic [KW-1:0] val, input logic [PW-1:0] p,
                        input logic exp_care, input logic exp_ovl, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v;
    cfg_mask = m; cfg_value = val; cfg_port = p;
    @(negedge clk);
    cfg_we = 1'b0;
    chk({req, " care err"}, 32'(cfg_err_care), 32'(exp_care));
    chk({req, " ovl err"}, 32'(cfg_err_ovl), 32'(exp_ovl));
  endtask

  task automatic lookup(input logic [KW-1:0] key, input logic exp_hit,
                        input logic [PW-1:0] exp_port, input string req);
    @(negedge clk);
    hdr_stb = 1'b1; hdr_key = key;
    @(negedge clk);
    hdr_stb = 1'b0;
    chk({req, " vld"}, 32'(res_vld), 32'd1);
    chk({req, " hit"}, 32'(res_hit), 32'(exp_hit));
    chk({req, " miss"}, 32'(res_miss), 32'(!exp_hit));
    chk({req, " port"}, 32'(res_port), 32'(exp_hit ? exp_port : 3'd0));
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) cfg_wr(3'(i), 1'b0, '0, '0, '0, 1'b0, 1'b0, "R8 clear");
  endtask

  task automatic t_reset();
    chk("R1 res_vld", 32'(res_vld), 0);
    chk("R1 res_hit", 32'(res_hit), 0);
    chk("R1 res_miss", 32'(res_miss), 0);
    chk("R1 res_port", 32'(res_port), 0);
    chk("R1 err_care", 32'(cfg_err_care), 0);
    chk("R1 err_ovl", 32'(cfg_err_ovl), 0);
    lookup(24'h123456, 1'b0, 3'd0, "R1 R4 empty lookup");
  endtask

  task automatic t_match();
    clear_all();
    cfg_wr(3'd2, 1'b1, 24'h980000, 24'h880000, 3'd5, 1'b0, 1'b0, "R2 load");
    lookup(24'h8812AB, 1'b1, 3'd5, "R2 exact");
    lookup(24'h0812AB, 1'b0, 3'd0, "R2 one bit wrong");
    lookup(24'h9812AB, 1'b0, 3'd0, "R2 zero bit wrong");
    lookup(24'hC8FFFF, 1'b1, 3'd5, "R2 dont care");
  endtask

  task automatic t_care();
    clear_all();
    cfg_wr(3'd0, 1'b1, 24'h00003F, 24'h0, 3'd2, 1'b1, 1'b0, "R6 six bits");
    lookup(24'h000000, 1'b0, 3'd0, "R6 not committed");
    cfg_wr(3'd0, 1'b1, 24'h00001F, 24'h0, 3'd2, 1'b0, 1'b0, "R6 five bits");
    lookup(24'h000000, 1'b1, 3'd2, "R6 committed");
  endtask

  task automatic t_overlap();
    clear_all();
    cfg_wr(3'd0, 1'b1, 24'h800000, 24'h800000, 3'd1, 1'b0, 1'b0, "R7 base");
    cfg_wr(3'd1, 1'b1, 24'h400000, 24'h400000, 3'd2, 1'b0, 1'b1, "R7 overlap");
    lookup(24'h400000, 1'b0, 3'd0, "R7 rejected");
    cfg_wr(3'd1, 1'b1, 24'h800000, 24'h000000, 3'd2, 1'b0, 1'b0, "R7 disjoint");
    lookup(24'h400000, 1'b1, 3'd2, "R7 disjoint hit");
    cfg_wr(3'd3, 1'b1, 24'hC00000, 24'hC00000, 3'd1, 1'b0, 1'b0, "R7 same port");
    lookup(24'hC00000, 1'b1, 3'd1, "R5 multi hit");
    cfg_wr(3'd1, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R8 clear one");
    lookup(24'h400000, 1'b0, 3'd0, "R8 cleared miss");
  endtask

  task automatic t_replace();
    clear_all();
    cfg_wr(3'd0, 1'b1, 24'h800000, 24'h800000, 3'd1, 1'b0, 1'b0, "R10 first");
    cfg_wr(3'd0, 1'b1, 24'h800000, 24'h800000, 3'd6, 1'b0, 1'b0, "R10 rewrite");
    lookup(24'h800001, 1'b1, 3'd6, "R10 new port");
  endtask

  task automatic t_outside();
    clear_all();
    cfg_wr(3'd5, 1'b1, 24'h000001, 24'hFFFFFF, 3'd4, 1'b0, 1'b0, "R11 load");
    lookup(24'h000001, 1'b1, 3'd4, "R11 hit");
    lookup(24'h000000, 1'b0, 3'd0, "R11 miss");
    cfg_wr(3'd6, 1'b1, 24'h000002, 24'hFFFFFD, 3'd3, 1'b0, 1'b1, "R11 overlap normalised");
  endtask

  task automatic t_same_cycle();
    clear_all();
    cfg_wr(3'd0, 1'b1, 24'h800000, 24'h800000, 3'd3, 1'b0, 1'b0, "R9 load");
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_valid = 1'b0; cfg_mask = '0; cfg_value = '0;
    hdr_stb = 1'b1; hdr_key = 24'h800000;
    @(negedge clk);
    cfg_we = 1'b0; hdr_stb = 1'b0;
    chk("R9 hit old table", 32'(res_hit), 1);
    chk("R9 port old table", 32'(res_port), 3);
    lookup(24'h800000, 1'b0, 3'd0, "R9 after clear");
  endtask

  task automatic t_fill();
    clear_all();
    for (int i = 0; i < 8; i++)
      cfg_wr(3'(i), 1'b1, 24'hE00000, 24'(i) << 21, 3'(i), 1'b0, 1'b0, "R2 fill");
    for (int i = 0; i < 8; i++)
      lookup((24'(i) << 21) | 24'h0ABCDE, 1'b1, 3'(i), "R2 R5 fill lookup");
    @(negedge clk);
    chk("R3 idle vld", 32'(res_vld), 0);
    chk("R3 idle port hold", 32'(res_port), 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_match();
    t_care();
    t_overlap();
    t_replace();
    t_outside();
    t_same_cycle();
    t_fill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule